// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address. It reads one page table entry from physical memory for each translation. A requester presents a virtual address, the base address of the current process's page table and a table limit. The walker keeps these values. It first compares the virtual page number with the limit. If the page number is inside the table, the walker computes the entry address and issues a single read on a request/response memory port. It then decodes the returned 32-bit entry.

The virtual address splits into a page number in the upper bits and a page offset in the lower bits. The offset passes through untouched. A completed walk raises a one-cycle done strobe that carries a result code:

| Code | Meaning |
|------|---------|
| 0 | Success |
| 1 | Page fault: the entry's valid bit is clear |
| 2 | Limit violation: the page number is at or beyond the limit |

On success the strobe also carries the physical address and the two-bit access rights. The walker handles one walk at a time.

Top module: `pt_walker`

## Requirements
- R1: The entry read address equals the table base plus four times the virtual page number, where the page number is vaddr[VA_W-1:OFF_W].
- R2: A memory read request stays asserted, with an unchanged address, until a cycle in which mem_req_ready is high. Exactly one read is issued per walk that passes the limit check.
- R3: If the page number is greater than or equal to the limit, no memory read is issued. The done strobe rises on the clock edge after the edge that accepted the request, with code 2, zero address and zero rights.
- R4: If bit 31 of the returned entry (valid) is 0, done carries code 1, with done_paddr and done_rights both 0.
- R5: If bit 31 is 1, done carries code 0. done_paddr is {entry[PPN_W-1:0], original page offset}. done_rights is entry[30:29], encoded 0 none, 1 read-only, 2 read/write, 3 executable. Entry bits 28 down to PPN_W are ignored.
- R6: done is high for exactly one cycle per accepted request.
- R7: req_ready is high only while no walk is in progress. A request presented during a walk is ignored and does not change that walk's result.
- R8: After reset, req_ready is 1, and mem_req_valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_base | input | PA_W | Physical base address of the page table |
| req_limit | input | VPN_W+1 | Number of entries in the table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Returned page table entry |
| done | output | 1 | One-cycle completion strobe |
| done_fault | output | 2 | Result code: 0 ok, 1 page fault, 2 limit violation |
| done_paddr | output | PPN_W+OFF_W | Translated physical address, 0 on a fault |
| done_rights | output | 2 | Access rights of the page, 0 on a fault |

## Verification
Every page number of the default configuration is walked under three table setups:
- a full-size table with an immediately ready memory;
- a partial limit with a stalling memory and a slow response;
- a zero limit.

Comparing partial and full limits separates page numbers just inside the bound from those at or past it, and the zero-limit pass shows that no read ever leaves the block. The synthetic table data mixes valid and invalid entries, all four rights codes and set filler bits. This separates correct field extraction and the fault path from wrong bit slicing. Offsets vary per walk, and every second walk is disturbed by a competing request. Together these show that the offset passes through and that a request arriving mid-walk is ignored.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   localparam int PTE_BYTES     = 4;
   localparam int PTE_W         = 8 * PTE_BYTES;
   localparam int PTE_VALID_BIT = 31;
   localparam int PTE_ACC_LSB   = 29;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_PAGE  = 2'd1,
      FLT_LIMIT = 2'd2
   } walk_fault_e;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_RO   = 2'd1,
      ACC_RW   = 2'd2,
      ACC_EXEC = 2'd3
   } acc_rights_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CHECK = 3'd1,
      ST_RDREQ = 3'd2,
      ST_WAIT  = 3'd3,
      ST_DONE  = 3'd4
   } walk_state_e;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
   parameter int VPN_W = 6,
   parameter int PA_W  = 32,
   localparam int LIM_W = VPN_W + 1,
   localparam int SH_W  = VPN_W + 2
) (
   input  logic [PA_W-1:0]  base,
   input  logic [VPN_W-1:0] vpn,
   input  logic [LIM_W-1:0] limit,
   output logic [PA_W-1:0]  entry_addr,
   output logic             over_limit
);
   logic [SH_W-1:0] scaled;
   logic [PA_W-1:0] offs;

   assign scaled     = {vpn, 2'b00};
   assign over_limit = ({1'b0, vpn} >= limit);

   generate
      if (PA_W > SH_W) begin : g_pad
         assign offs = {{(PA_W - SH_W){1'b0}}, scaled};
      end else if (PA_W == SH_W) begin : g_exact
         assign offs = scaled;
      end else begin : g_bad
         $error("pt_addr_gen: PA_W too narrow for table offset");
      end
   endgenerate

   assign entry_addr = base + offs;
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode
   import pt_walker_pkg::*;
#(
   parameter int PPN_W = 10
) (
   input  logic [PTE_W-1:0] entry,
   output logic             present,
   output logic [1:0]       rights,
   output logic [PPN_W-1:0] ppn
);
   generate
      if (PPN_W > PTE_ACC_LSB) begin : g_bad
         $error("pt_pte_decode: PPN_W overlaps the rights field");
      end
   endgenerate

   assign present = entry[PTE_VALID_BIT];
   assign rights  = entry[PTE_ACC_LSB +: 2];
   assign ppn     = entry[PPN_W-1:0];
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
   import pt_walker_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_fire,
   input  logic        over_limit,
   input  logic        mem_req_ready,
   input  logic        mem_rsp_valid,
   output walk_state_e state
);
   walk_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (req_fire) nxt = ST_CHECK;
         ST_CHECK: nxt = over_limit ? ST_DONE : ST_RDREQ;
         ST_RDREQ: if (mem_req_ready) nxt = ST_WAIT;
         ST_WAIT:  if (mem_rsp_valid) nxt = ST_DONE;
         ST_DONE:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int VPN_W = 6,
   parameter int OFF_W = 12,
   parameter int PPN_W = 10,
   parameter int PA_W  = 32,
   localparam int VA_W  = VPN_W + OFF_W,
   localparam int LIM_W = VPN_W + 1,
   localparam int OUT_W = PPN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [PA_W-1:0]  req_base,
   input  logic [LIM_W-1:0] req_limit,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [31:0]      mem_rsp_data,
   output logic             done,
   output logic [1:0]       done_fault,
   output logic [OUT_W-1:0] done_paddr,
   output logic [1:0]       done_rights
);
   generate
      if (VPN_W < 1 || OFF_W < 2) begin : g_bad_va
         $error("pt_walker: address split out of range");
      end
   endgenerate

   walk_state_e      st;
   logic             req_fire;
   logic [VPN_W-1:0] vpn_q;
   logic [OFF_W-1:0] off_q;
   logic [PA_W-1:0]  base_q;
   logic [LIM_W-1:0] lim_q;
   logic             over_limit;
   logic             pte_present;
   logic [1:0]       pte_rights;
   logic [PPN_W-1:0] pte_ppn;

   assign req_ready = (st == ST_IDLE);
   assign req_fire  = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q  <= '0;
         off_q  <= '0;
         base_q <= '0;
         lim_q  <= '0;
      end else if (req_fire) begin
         vpn_q  <= req_vaddr[VA_W-1:OFF_W];
         off_q  <= req_vaddr[OFF_W-1:0];
         base_q <= req_base;
         lim_q  <= req_limit;
      end
   end

   pt_walk_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_fire      (req_fire),
      .over_limit    (over_limit),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .state         (st)
   );

   pt_addr_gen #(.VPN_W(VPN_W), .PA_W(PA_W)) u_addr (
      .base       (base_q),
      .vpn        (vpn_q),
      .limit      (lim_q),
      .entry_addr (mem_req_addr),
      .over_limit (over_limit)
   );

   pt_pte_decode #(.PPN_W(PPN_W)) u_dec (
      .entry   (mem_rsp_data),
      .present (pte_present),
      .rights  (pte_rights),
      .ppn     (pte_ppn)
   );

   assign mem_req_valid = (st == ST_RDREQ);
   assign done          = (st == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_fault  <= FLT_NONE;
         done_paddr  <= '0;
         done_rights <= ACC_NONE;
      end else if (st == ST_CHECK && over_limit) begin
         done_fault  <= FLT_LIMIT;
         done_paddr  <= '0;
         done_rights <= ACC_NONE;
      end else if (st == ST_WAIT && mem_rsp_valid) begin
         if (pte_present) begin
            done_fault  <= FLT_NONE;
            done_paddr  <= {pte_ppn, off_q};
            done_rights <= pte_rights;
         end else begin
            done_fault  <= FLT_PAGE;
            done_paddr  <= '0;
            done_rights <= ACC_NONE;
         end
      end
   end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int PA_W  = 32,
   parameter int OUT_W = 22
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic             done,
   input logic [1:0]       done_fault,
   input logic [OUT_W-1:0] done_paddr,
   input logic [1:0]       done_rights
);
   a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   a_r3_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault == 2'd2) |-> $past(!mem_req_valid));

   a_r4_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault != 2'd0) |-> (done_paddr == '0 && done_rights == 2'd0));

   a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !done));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .OUT_W(OUT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .done          (done),
   .done_fault    (done_fault),
   .done_paddr    (done_paddr),
   .done_rights   (done_rights)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
   localparam int VPN_W = 6;
   localparam int OFF_W = 12;
   localparam int PPN_W = 10;
   localparam int PA_W  = 32;
   localparam int VA_W  = VPN_W + OFF_W;
   localparam int LIM_W = VPN_W + 1;
   localparam int OUT_W = PPN_W + OFF_W;

   logic             clk = 0;
   logic             rst_n = 0;
   logic             req_valid = 0;
   logic             req_ready;
   logic [VA_W-1:0]  req_vaddr = '0;
   logic [PA_W-1:0]  req_base = '0;
   logic [LIM_W-1:0] req_limit = '0;
   logic             mem_req_valid;
   logic             mem_req_ready;
   logic [PA_W-1:0]  mem_req_addr;
   logic             mem_rsp_valid;
   logic [31:0]      mem_rsp_data;
   logic             done;
   logic [1:0]       done_fault;
   logic [OUT_W-1:0] done_paddr;
   logic [1:0]       done_rights;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   pt_walker #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PA_W(PA_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_base(req_base), .req_limit(req_limit),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
      .done_paddr(done_paddr), .done_rights(done_rights)
   );

   function automatic logic [31:0] ent(input logic [31:0] a);
      logic [31:0] w;
      logic [31:0] p;
      w = a >> 2;
      p = w * 37 + 11;
      return {((w % 5) != 2), w[2:1], {(29 - PPN_W){1'b1}}, p[PPN_W-1:0]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model
   int stall_cfg = 0;
   int delay_cfg = 0;
   int hs_count = 0;
   logic [31:0] cap_addr = '0;

   initial begin
      bit hs_seen;
      bit busy;
      int stall_cnt;
      int wait_cnt;
      hs_seen = 0; busy = 0; stall_cnt = 0; wait_cnt = 0;
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 0;
         if (hs_seen) begin
            cap_addr = mem_req_addr;
            hs_count++;
            mem_req_ready = 0;
            busy = 1;
            wait_cnt = delay_cfg;
            stall_cnt = 0;
         end else if (busy) begin
            if (wait_cnt == 0) begin
               mem_rsp_valid = 1;
               mem_rsp_data = ent(cap_addr);
               busy = 0;
            end else wait_cnt--;
         end else if (mem_req_valid) begin
            if (stall_cnt >= stall_cfg) mem_req_ready = 1;
            else stall_cnt++;
         end
         hs_seen = mem_req_valid && mem_req_ready;
      end
   end

   task automatic walk(input logic [VA_W-1:0] va, input logic [31:0] base,
                       input logic [LIM_W-1:0] lim, input bit noise);
      logic [VPN_W-1:0] vpn;
      logic [OFF_W-1:0] off;
      logic [31:0] eaddr;
      logic [31:0] e;
      int hs0;
      int lat;
      bit busy_ready;
      vpn = va[VA_W-1:OFF_W];
      off = va[OFF_W-1:0];
      hs0 = hs_count;
      @(negedge clk);
      req_valid = 1; req_vaddr = va; req_base = base; req_limit = lim;
      @(negedge clk);
      if (noise) begin
         req_vaddr = ~va; req_base = base + 32'h100; req_limit = '1;
      end else req_valid = 0;
      lat = 0;
      busy_ready = 0;
      do begin
         if (req_ready) busy_ready = 1;
         @(negedge clk);
         lat++;
      end while (!done && lat < 500);
      req_valid = 0;
      chk("R6 done seen", {31'b0, done}, 32'd1);
      if (noise) chk("R7 ready low during walk", {31'b0, busy_ready}, 32'd0);
      if ({1'b0, vpn} >= lim) begin
         chk("R3 code", {30'b0, done_fault}, 32'd2);
         chk("R3 paddr", {10'b0, done_paddr}, 32'd0);
         chk("R3 rights", {30'b0, done_rights}, 32'd0);
         chk("R3 latency", lat, 32'd1);
         chk("R3 no read", hs_count - hs0, 32'd0);
      end else begin
         eaddr = base + {vpn, 2'b00};
         e = ent(eaddr);
         chk("R1 entry addr", cap_addr, eaddr);
         chk("R2 one read", hs_count - hs0, 32'd1);
         if (e[31]) begin
            chk("R5 code", {30'b0, done_fault}, 32'd0);
            chk("R5 paddr", {10'b0, done_paddr}, {10'b0, e[PPN_W-1:0], off});
            chk("R5 rights", {30'b0, done_rights}, {30'b0, e[30:29]});
         end else begin
            chk("R4 code", {30'b0, done_fault}, 32'd1);
            chk("R4 paddr", {10'b0, done_paddr}, 32'd0);
            chk("R4 rights", {30'b0, done_rights}, 32'd0);
         end
      end
      @(negedge clk);
      chk("R6 strobe dropped", {31'b0, done}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 req_ready", {31'b0, req_ready}, 32'd1);
      chk("R8 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
      chk("R8 done", {31'b0, done}, 32'd0);
      rst_n = 1;
      for (int cfg = 0; cfg < 3; cfg++) begin
         logic [31:0] base;
         logic [LIM_W-1:0] lim;
         case (cfg)
            0: begin base = 32'h0001_0000; lim = 7'd64; stall_cfg = 0; delay_cfg = 0; end
            1: begin base = 32'h8000_0FF0; lim = 7'd40; stall_cfg = 2; delay_cfg = 3; end
            default: begin base = 32'hFFFF_FF80; lim = 7'd0; stall_cfg = 1; delay_cfg = 1; end
         endcase
         for (int v = 0; v < (1 << VPN_W); v++) begin
            logic [OFF_W-1:0] off;
            logic [VPN_W-1:0] vv;
            off = OFF_W'(v * 97 + cfg * 13 + 5);
            vv = VPN_W'(v);
            walk({vv, off}, base, lim, v[0]);
         end
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule